// File: doc/BRIEF.md
# Event Status, Aging and PHY Reset Register Bank

This block is a small bank of control and status registers for a cell-interface bridge. It sits on a simple synchronous register port with a write strobe, an address, write data and a combinational read. It records three kinds of event in sticky status bits. The first is an edge on an asynchronous PHY interrupt pin. The second is a receive-side out-of-range address error. The third is a transmit cell that was dropped because the PHY gave no response. Software clears a status bit by writing 1 to it.

The PHY interrupt and the address error can each raise a one-cycle notification request. This happens only when the source is enabled in a mask register. A notification-cell generator outside this block consumes that strobe. Each of those two sources also has an aging counter. The counter sets a timeout flag once the status bit has stayed uncleared for a configurable number of cycles. The default count is 25 ms at 100 MHz. The timeout flag falls the moment the status bit is cleared.

Software can also fire a self-timed, active-low PHY reset pulse. Five configuration bits are taken from strap pins while reset is held. Software can overwrite them afterwards, and they are driven out to the rest of the bridge.

Top module: `evt_csr_bank`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the status, timeout, mask and PHY-reset registers read 0, `notify_req` is 0 and `phy_rst_n` is 1.
- R2: While `rst` is high, the mode register (address BASE+0, bits 4:0) loads `strap_mode`. The bits are: bit0 device-port width, bit1 device-port receive clock is an input, bit2 UTOPIA 2 width of 16 bits, bit3 UTOPIA 2 style management, bit4 header init from EEPROM. After reset, a write to BASE+0 replaces the register, and `mode_cfg` always shows its value.
- R3: The read port returns mode at BASE+0, PHY reset at BASE+1, mask at BASE+2, status at BASE+3 and timeout at BASE+4, in the same cycle that the address is presented. Unused upper bits read 0, and any other address reads 0.
- R4: A rising edge on the asynchronous `phy_irq_pin` sets status bit0 at the third clock edge after it is first sampled. A pin held high does not set the bit again after it has been cleared.
- R5: Status bit1 sets at a clock edge where `rx_addr_err` is high. Status bit2 sets at a clock edge where `tx_cell_drop` is high.
- R6: Writing 1 to a bit of the status register (BASE+3) clears that bit, and writing 0 leaves it unchanged. An event arriving in the same cycle as the clear keeps the bit set.
- R7: `notify_req[0]` (PHY interrupt) and `notify_req[1]` (address error) pulse for exactly one cycle. The pulse coincides with the cycle in which the status bit first reads 1 after being 0, and only when mask bit0 or bit1 respectively (BASE+2) was 1. With the mask bit at 0 no pulse is made.
- R8: Timeout bit0 and bit1 (BASE+4) read 1 once their status bit has read 1 for AGE_CYCLES consecutive cycles. Each reads 0 in the same cycle its status bit reads 0, and the count restarts from zero on the next setting.
- R9: Writing 1 to bit0 of BASE+1 drives `phy_rst_n` low for exactly PULSE_CYCLES cycles starting in the cycle after the write. Bit0 reads 1 while the pulse runs and clears itself after it. Writing 0 has no effect.
- R10: Writes to the timeout register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_mode | input | 5 | Strap values captured into the mode register during reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 16 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| phy_irq_pin | input | 1 | Asynchronous PHY interrupt pin, active high |
| rx_addr_err | input | 1 | Receive out-of-range address error event |
| tx_cell_drop | input | 1 | Transmit cell dropped event |
| notify_req | output | 2 | One-cycle notification requests: bit0 PHY interrupt, bit1 address error |
| phy_rst_n | output | 1 | Active-low PHY reset pulse |
| mode_cfg | output | 5 | Current mode register contents |

## Verification
Two functions can land on the same clock edge: a hardware event setting a status bit and a software write clearing it. The bench provokes this by holding `tx_cell_drop` high in the very cycle the write-1-to-clear for bit2 is issued. It judges the result by reading the bit back as still set. The same collision also matters for aging, because a clear that loses to a new event must not restart the timeout count. A behavioural model that runs alongside on every clock compares the read data, notification strobes, reset pin and mode outputs for every address the bench touches.

// File: rtl/evt_csr_pkg.sv
package evt_csr_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int MODE_BITS = 5;
    localparam int EVT_BITS  = 3;
    localparam int AGED_SRC  = 2;

    typedef enum logic [2:0] {
        SEL_MODE,
        SEL_PRST,
        SEL_MASK,
        SEL_STAT,
        SEL_AGE,
        SEL_NONE
    } csr_sel_e;

    typedef struct packed {
        logic cell_drop;
        logic addr_err;
        logic phy_irq;
    } evt_vec_t;

    function automatic csr_sel_e csr_decode(input logic [ADDR_W-1:0] a,
                                            input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] off;
        off = a - base;
        case (off)
            16'd0:   return SEL_MODE;
            16'd1:   return SEL_PRST;
            16'd2:   return SEL_MASK;
            16'd3:   return SEL_STAT;
            16'd4:   return SEL_AGE;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], din};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/evt_age_timer.sv
module evt_age_timer #(
    parameter int LIMIT = 2500000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign expired = active && (cnt == LIM);
endmodule

// File: rtl/phy_rst_pulser.sv
module phy_rst_pulser #(
    parameter int PULSE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic busy
);
    localparam int CW = $clog2(PULSE);
    localparam logic [CW-1:0] LAST = CW'(PULSE - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (fire) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/evt_csr_bank.sv
module evt_csr_bank
    import evt_csr_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR    = 16'h8006,
    parameter int          AGE_CYCLES   = 2500000,
    parameter int          PULSE_CYCLES = 16,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MODE_BITS-1:0] strap_mode,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 phy_irq_pin,
    input  logic                 rx_addr_err,
    input  logic                 tx_cell_drop,
    output logic [AGED_SRC-1:0]  notify_req,
    output logic                 phy_rst_n,
    output logic [MODE_BITS-1:0] mode_cfg
);
    csr_sel_e sel;
    logic wr_mode, wr_prst, wr_mask, wr_stat;
    logic irq_rise;
    evt_vec_t evt_in;
    logic [EVT_BITS-1:0]  status_q, status_d, w1c;
    logic [AGED_SRC-1:0]  mask_q, notify_q, age_flag;
    logic [MODE_BITS-1:0] mode_q;
    logic prst_busy;
    logic unused_wdata;

    assign sel     = csr_decode(addr, BASE_ADDR);
    assign wr_mode = wr_en && (sel == SEL_MODE);
    assign wr_prst = wr_en && (sel == SEL_PRST);
    assign wr_mask = wr_en && (sel == SEL_MASK);
    assign wr_stat = wr_en && (sel == SEL_STAT);
    assign unused_wdata = ^wr_data[DATA_W-1:MODE_BITS];

    evt_pin_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (phy_irq_pin),
        .rise (irq_rise)
    );

    always_comb begin
        evt_in.phy_irq   = irq_rise;
        evt_in.addr_err  = rx_addr_err;
        evt_in.cell_drop = tx_cell_drop;
        w1c      = wr_stat ? wr_data[EVT_BITS-1:0] : '0;
        status_d = (status_q & ~w1c) | evt_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            notify_q <= '0;
            mask_q   <= '0;
            mode_q   <= strap_mode;
        end else begin
            status_q <= status_d;
            notify_q <= status_d[AGED_SRC-1:0] & ~status_q[AGED_SRC-1:0] & mask_q;
            if (wr_mask) mask_q <= wr_data[AGED_SRC-1:0];
            if (wr_mode) mode_q <= wr_data[MODE_BITS-1:0];
        end
    end

    for (genvar g = 0; g < AGED_SRC; g++) begin : g_age
        evt_age_timer #(.LIMIT(AGE_CYCLES)) u_age (
            .clk     (clk),
            .rst     (rst),
            .active  (status_q[g]),
            .expired (age_flag[g])
        );
    end

    phy_rst_pulser #(.PULSE(PULSE_CYCLES)) u_prst (
        .clk  (clk),
        .rst  (rst),
        .fire (wr_prst && wr_data[0]),
        .busy (prst_busy)
    );

    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_MODE: rd_data[MODE_BITS-1:0] = mode_q;
            SEL_PRST: rd_data[0]             = prst_busy;
            SEL_MASK: rd_data[AGED_SRC-1:0]  = mask_q;
            SEL_STAT: rd_data[EVT_BITS-1:0]  = status_q;
            SEL_AGE:  rd_data[AGED_SRC-1:0]  = age_flag;
            default:  rd_data = '0;
        endcase
    end

    assign notify_req = notify_q;
    assign phy_rst_n  = ~prst_busy;
    assign mode_cfg   = mode_q;
endmodule

// File: rtl/evt_csr_checker.sv
module evt_csr_checker #(
    parameter logic [15:0] BASE_ADDR = 16'h8006
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] addr,
    input logic [7:0]  wr_data,
    input logic [2:0]  status_q,
    input logic [1:0]  mask_q,
    input logic [1:0]  age_flag,
    input logic [1:0]  notify_req,
    input logic        phy_rst_n,
    input logic [4:0]  mode_cfg
);
    // R7: a strobe only with a fresh, unmasked status edge
    a_r7_notify_phy: assert property (@(posedge clk) disable iff (rst)
        notify_req[0] |-> (status_q[0] && !$past(status_q[0]) && $past(mask_q[0])));
    a_r7_notify_addr: assert property (@(posedge clk) disable iff (rst)
        notify_req[1] |-> (status_q[1] && !$past(status_q[1]) && $past(mask_q[1])));
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (notify_req != 2'b00) |=> ((notify_req & $past(notify_req)) == 2'b00));
    // R8: timeout never outlives its status bit
    a_r8_age_needs_status: assert property (@(posedge clk) disable iff (rst)
        ((age_flag & ~status_q[1:0]) == 2'b00));
    a_r8_age_rise_held: assert property (@(posedge clk) disable iff (rst)
        $rose(age_flag[1]) |-> $past(status_q[1]));
    // R6: a status bit only falls after a write-one clear
    a_r6_clear_by_write: assert property (@(posedge clk) disable iff (rst)
        $fell(status_q[1]) |-> $past(wr_en && addr == BASE_ADDR + 16'd3 && wr_data[1]));
    // R9: a reset pulse starts only from a software request
    a_r9_pulse_source: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_rst_n) |-> $past(wr_en && addr == BASE_ADDR + 16'd1 && wr_data[0]));
    // R2: mode changes only through its own write
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en && addr == BASE_ADDR)) |-> $stable(mode_cfg));
endmodule

bind evt_csr_bank evt_csr_checker #(.BASE_ADDR(BASE_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .age_flag   (age_flag),
    .notify_req (notify_req),
    .phy_rst_n  (phy_rst_n),
    .mode_cfg   (mode_cfg)
);

// File: tb/evt_csr_bank_test.sv
module evt_csr_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int AGE   = 20;
    localparam int PULSE = 16;
    localparam logic [15:0] BASE = 16'h8006;
    localparam logic [15:0] A_MODE = BASE, A_PRST = BASE + 1, A_MASK = BASE + 2,
                            A_STAT = BASE + 3, A_AGE = BASE + 4;

    logic clk = 0, rst = 1;
    logic [4:0]  strap = 5'h16;
    logic        wr_en = 0;
    logic [15:0] addr = BASE;
    logic [7:0]  wr_data = 0;
    logic        pin = 0, rx = 0, tx = 0;
    logic [7:0]  rd_data;
    logic [1:0]  notify_req;
    logic        phy_rst_n;
    logic [4:0]  mode_cfg;

    int n_chk = 0, n_err = 0, n_not0 = 0, n_not1 = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_csr_bank #(.BASE_ADDR(BASE), .AGE_CYCLES(AGE), .PULSE_CYCLES(PULSE)) uut (
        .clk(clk), .rst(rst), .strap_mode(strap), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .phy_irq_pin(pin),
        .rx_addr_err(rx), .tx_cell_drop(tx), .notify_req(notify_req),
        .phy_rst_n(phy_rst_n), .mode_cfg(mode_cfg));

    // behavioural reference
    logic [2:0] m_status;
    logic [1:0] m_mask, m_notify;
    logic [4:0] m_mode;
    int m_held [2];
    int m_low;
    logic pin_q[$];

    always @(posedge clk) begin
        logic [2:0] setv, clrv, nst;
        logic rise;
        if (rst) begin
            m_status = 0; m_mask = 0; m_notify = 0; m_mode = strap;
            m_held[0] = 0; m_held[1] = 0; m_low = 0;
            pin_q = '{1'b0, 1'b0, 1'b0};
        end else begin
            rise = pin_q[1] && !pin_q[0];
            pin_q.push_back(pin);
            void'(pin_q.pop_front());
            setv = {tx, rx, rise};
            clrv = (wr_en && addr == A_STAT) ? wr_data[2:0] : 3'b0;
            nst  = (m_status & ~clrv) | setv;
            m_notify = nst[1:0] & ~m_status[1:0] & m_mask;
            for (int i = 0; i < 2; i++)
                m_held[i] = m_status[i] ? m_held[i] + 1 : 0;
            m_status = nst;
            if (wr_en && addr == A_MODE) m_mode = wr_data[4:0];
            if (wr_en && addr == A_MASK) m_mask = wr_data[1:0];
            if (wr_en && addr == A_PRST && wr_data[0]) m_low = PULSE;
            else if (m_low > 0) m_low--;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        logic [1:0] to;
        for (int i = 0; i < 2; i++) to[i] = m_status[i] && (m_held[i] >= AGE);
        case (a)
            A_MODE: return {3'b0, m_mode};
            A_PRST: return {7'b0, m_low != 0};
            A_MASK: return {6'b0, m_mask};
            A_STAT: return {5'b0, m_status};
            A_AGE:  return {6'b0, to};
            default: return 8'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 model rd_data", rd_data, exp_rd(addr));
            chk("R7 model notify_req", notify_req, m_notify);
            chk("R9 model phy_rst_n", phy_rst_n, m_low == 0);
            chk("R2 model mode_cfg", mode_cfg, m_mode);
            if (notify_req[0]) n_not0++;
            if (notify_req[1]) n_not1++;
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        chk(tag, rd_data, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int base_n, lows;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 phy_rst_n after reset", phy_rst_n, 1);
        chk("R1 notify after reset", notify_req, 0);
        rd(A_STAT, 0, "R1 status reset");
        rd(A_AGE,  0, "R1 timeout reset");
        rd(A_MASK, 0, "R1 mask reset");
        rd(A_PRST, 0, "R1 prst reset");
        rd(A_MODE, 8'h16, "R2 strap capture");
        rd(16'h8005, 0, "R3 below range");
        rd(16'h800B, 0, "R3 above range");
        wr(A_MODE, 8'hEB);
        rd(A_MODE, 8'h0B, "R2 R3 mode write, upper bits zero");

        // R5 R7 R8 R10: address error, notify, aging
        wr(A_MASK, 8'h03);
        base_n = n_not1;
        @(posedge clk); #1 rx = 1;
        @(posedge clk); #1 rx = 0;
        rd(A_STAT, 8'h02, "R5 addr error sets bit1");
        chk("R7 one notify strobe", n_not1 - base_n, 1);
        idle(AGE / 2);
        rd(A_AGE, 0, "R8 not yet aged");
        idle(AGE);
        rd(A_AGE, 8'h02, "R8 aged bit1");
        wr(A_AGE, 8'h00);
        rd(A_AGE, 8'h02, "R10 timeout write ignored");
        wr(A_STAT, 8'h02);
        rd(A_AGE, 0, "R8 timeout drops with status");
        rd(A_STAT, 0, "R6 clear bit1");

        // R4: synchronised pin edge
        base_n = n_not0;
        @(posedge clk); #1 pin = 1;
        idle(4);
        rd(A_STAT, 8'h01, "R4 pin sets bit0");
        chk("R7 phy notify strobe", n_not0 - base_n, 1);
        wr(A_STAT, 8'h01);
        idle(3);
        rd(A_STAT, 0, "R4 held pin does not re-set");
        pin = 0;

        // R6: clear colliding with event; write 0 no effect
        @(posedge clk); #1 tx = 1;
        @(posedge clk); #1 tx = 0;
        rd(A_STAT, 8'h04, "R5 cell drop sets bit2");
        @(posedge clk); #1;
        tx = 1; wr_en = 1; addr = A_STAT; wr_data = 8'h04;
        @(posedge clk); #1 tx = 0; wr_en = 0;
        rd(A_STAT, 8'h04, "R6 event beats clear");
        wr(A_STAT, 8'h00);
        rd(A_STAT, 8'h04, "R6 write zero no effect");
        wr(A_STAT, 8'h04);
        rd(A_STAT, 0, "R6 clear bit2");

        // R7: masked source
        wr(A_MASK, 8'h00);
        base_n = n_not1;
        @(posedge clk); #1 rx = 1;
        @(posedge clk); #1 rx = 0;
        idle(2);
        chk("R7 masked no strobe", n_not1 - base_n, 0);
        rd(A_STAT, 8'h02, "R7 masked status still set");
        wr(A_STAT, 8'h02);

        // R9: reset pulse
        wr(A_PRST, 8'h00);
        @(negedge clk);
        chk("R9 write zero no pulse", phy_rst_n, 1);
        wr(A_PRST, 8'h01);
        lows = 0;
        forever begin
            @(negedge clk);
            if (phy_rst_n === 1'b0 && lows < 100) lows++;
            else break;
        end
        chk("R9 pulse length", lows, PULSE);
        rd(A_PRST, 0, "R9 self clear");
        idle(2);
        finish_run();
    end
endmodule